// File: doc/BRIEF.md
# Prioritized Audio Interrupt Event Controller

This block gathers a small set of numbered event sources into a pending set. It drives one fast-interrupt line towards an embedded sound core. While any event is pending, the line is high. The block also keeps an event-number register. This register normally names the lowest-numbered pending event, and the core reads it to find out what to service.

The core acknowledges by writing to a clear register. Only every fourth write to that register retires an event. A retire removes the lowest-numbered pending event. The event-number register is then reloaded with the next pending event above it.

A timer event (number 2 by default) is pending straight out of reset. All pins are plain control strobes and status levels. There is no valid/ready stream and no back-pressure: each strobe acts in the cycle it is high.

Top module: `audio_evt_ctrl`

## Requirements
- R1: While reset is held and just after it is released, the pending set holds only event 2, `cur_evt_o` reads 2 and `fiq_o` is 1.
- R2: A high bit k of `evt_raise_i` sets pending bit k at the next clock edge. After every edge, `fiq_o` is 1 exactly when the pending set is non-empty.
- R3: For each raised event k, `cur_evt_o` is loaded with k if it currently reads 0 or if k is smaller than its value. Several events raised in one cycle are applied in ascending order of number.
- R4: A 2-bit count tracks cycles with `ack_wr_i` high. The first three such writes change neither output. The fourth write performs a retire and returns the count to zero.
- R5: A retire clears the lowest-numbered pending bit. `cur_evt_o` is then loaded with the lowest pending number above it, or is left unchanged if no such event exists.
- R6: A fourth write that finds the pending set empty changes neither output, but it still returns the count to zero.
- R7: When a fourth write and raises arrive in the same cycle, the retire (including its reload of `cur_evt_o`) is applied first, and the raises second.
- R8: Raising an event that is already pending leaves the pending set unchanged. Its only effect is the R3 comparison on `cur_evt_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| evt_raise_i | input | 8 | One raise strobe per event number |
| ack_wr_i | input | 1 | Write strobe to the clear register |
| fiq_o | output | 1 | Fast-interrupt request line |
| cur_evt_o | output | 3 | Event-number register |

## Verification
The hardest cases to reach are those where the value 0 in the event-number register behaves as "empty". Event 0 can be retired while a higher event is raised in the same cycle. Event 0 can also be raised together with higher events. Either way, the stored 0 lets a larger number overwrite it. The stimulus reaches these cases in two ways. First, it sweeps every raise pattern on top of the reset state, then drains the set one retire at a time, continuing past empty so that the clear count wraps. Second, a long pseudo-random run mixes raises with clear writes, so that fourth writes land in the same cycle as raises in many different states.

// File: rtl/evt_irq_pkg.sv
package evt_irq_pkg;
  localparam int unsigned DEF_NUM_EVT  = 8;
  localparam int unsigned DEF_CLR_DIV  = 4;
  localparam int unsigned DEF_BOOT_EVT = 2;
endpackage

// File: rtl/evt_clr_div.sv
module evt_clr_div #(
  parameter int unsigned CLR_DIV = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr_i,
  output logic fire_o
);
  localparam int unsigned CW = (CLR_DIV > 2) ? $clog2(CLR_DIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(CLR_DIV - 1);

  logic [CW-1:0] cnt_q;

  // The write that finds the count at its last value is the one that retires.
  assign fire_o = clr_i && (cnt_q == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (clr_i) begin
      cnt_q <= fire_o ? '0 : cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/evt_pend_set.sv
module evt_pend_set #(
  parameter int unsigned NUM_EVT  = 8,
  parameter int unsigned BOOT_EVT = 2,
  parameter int unsigned IW       = 3
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_EVT-1:0] raise_i,
  input  logic               retire_i,
  output logic [NUM_EVT-1:0] pend_q,
  output logic [NUM_EVT-1:0] pend_d,
  output logic               next_found_o,
  output logic [IW-1:0]      next_idx_o
);
  logic [NUM_EVT-1:0] post_ret;
  logic               cleared;

  // Retire step: drop the lowest set bit.
  always_comb begin
    post_ret = pend_q;
    cleared  = 1'b0;
    if (retire_i) begin
      for (int i = 0; i < NUM_EVT; i++) begin
        if (!cleared && pend_q[i]) begin
          post_ret[i] = 1'b0;
          cleared     = 1'b1;
        end
      end
    end
  end

  // Next search: after the clear, every bit below the retired index is
  // zero, so the lowest remaining bit is the next one at or above it.
  always_comb begin
    next_found_o = 1'b0;
    next_idx_o   = '0;
    for (int i = 0; i < NUM_EVT; i++) begin
      if (!next_found_o && post_ret[i]) begin
        next_found_o = cleared;
        next_idx_o   = IW'(i);
      end
    end
  end

  // The raises are applied after the retire.
  assign pend_d = post_ret | raise_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= NUM_EVT'(1) << BOOT_EVT;
    end else begin
      pend_q <= pend_d;
    end
  end
endmodule

// File: rtl/evt_num_reg.sv
module evt_num_reg #(
  parameter int unsigned NUM_EVT  = 8,
  parameter int unsigned BOOT_EVT = 2,
  parameter int unsigned IW       = 3
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_EVT-1:0] raise_i,
  input  logic               next_found_i,
  input  logic [IW-1:0]      next_idx_i,
  output logic [IW-1:0]      evt_q
);
  logic [IW-1:0] evt_d;

  always_comb begin
    // The retire reload is applied first.
    evt_d = next_found_i ? next_idx_i : evt_q;
    // Then each raise, in ascending order. A stored 0 reads as "empty",
    // so any raised event can replace it.
    for (int i = 0; i < NUM_EVT; i++) begin
      if (raise_i[i] && ((evt_d == '0) || (IW'(i) < evt_d))) begin
        evt_d = IW'(i);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      evt_q <= IW'(BOOT_EVT);
    end else begin
      evt_q <= evt_d;
    end
  end
endmodule

// File: rtl/audio_evt_ctrl.sv
module audio_evt_ctrl #(
  parameter int unsigned NUM_EVT  = evt_irq_pkg::DEF_NUM_EVT,
  parameter int unsigned CLR_DIV  = evt_irq_pkg::DEF_CLR_DIV,
  parameter int unsigned BOOT_EVT = evt_irq_pkg::DEF_BOOT_EVT,
  localparam int unsigned IW      = (NUM_EVT > 2) ? $clog2(NUM_EVT) : 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_EVT-1:0] evt_raise_i,
  input  logic               ack_wr_i,
  output logic               fiq_o,
  output logic [IW-1:0]      cur_evt_o
);
  logic               retire_w;
  logic [NUM_EVT-1:0] pend_q;
  logic [NUM_EVT-1:0] pend_d;
  logic               next_found;
  logic [IW-1:0]      next_idx;

  evt_clr_div #(.CLR_DIV(CLR_DIV)) u_div (
    .clk    (clk),
    .rst_n  (rst_n),
    .clr_i  (ack_wr_i),
    .fire_o (retire_w)
  );

  evt_pend_set #(.NUM_EVT(NUM_EVT), .BOOT_EVT(BOOT_EVT), .IW(IW)) u_pend (
    .clk          (clk),
    .rst_n        (rst_n),
    .raise_i      (evt_raise_i),
    .retire_i     (retire_w),
    .pend_q       (pend_q),
    .pend_d       (pend_d),
    .next_found_o (next_found),
    .next_idx_o   (next_idx)
  );

  evt_num_reg #(.NUM_EVT(NUM_EVT), .BOOT_EVT(BOOT_EVT), .IW(IW)) u_num (
    .clk          (clk),
    .rst_n        (rst_n),
    .raise_i      (evt_raise_i),
    .next_found_i (next_found),
    .next_idx_i   (next_idx),
    .evt_q        (cur_evt_o)
  );

  // The line is raised when a raise finds the set empty, and dropped when a
  // retire empties it. Registering "set non-empty" gives exactly that.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fiq_o <= 1'b1;
    end else begin
      fiq_o <= |pend_d;
    end
  end
endmodule

// File: rtl/evt_irq_chk.sv
module evt_irq_chk #(
  parameter int unsigned NUM_EVT = 8,
  parameter int unsigned IW      = 3
) (
  input logic               clk,
  input logic               rst_n,
  input logic [NUM_EVT-1:0] evt_raise_i,
  input logic               ack_wr_i,
  input logic               fiq_o,
  input logic [IW-1:0]      cur_evt_o,
  input logic [NUM_EVT-1:0] pend_q,
  input logic               retire_w
);
  AST_FIQ_TRACKS_SET: assert property (@(posedge clk) disable iff (!rst_n)
    fiq_o == (|pend_q)); // R2

  AST_RAISE_SETS_FIQ: assert property (@(posedge clk) disable iff (!rst_n)
    (|evt_raise_i) |=> fiq_o); // R2

  AST_RETIRE_NEEDS_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    retire_w |-> ack_wr_i); // R4

  AST_QUIET_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (!retire_w && (evt_raise_i == '0)) |=> ($stable(cur_evt_o) && $stable(fiq_o))); // R4

  AST_RETIRE_DROPS_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    (retire_w && (|pend_q) && (evt_raise_i == '0))
      |=> ($countones(pend_q) + 1 == $countones($past(pend_q)))); // R5

  AST_EMPTY_RETIRE_NOP: assert property (@(posedge clk) disable iff (!rst_n)
    (retire_w && (pend_q == '0) && (evt_raise_i == '0))
      |=> ($stable(cur_evt_o) && !fiq_o)); // R6
endmodule

bind audio_evt_ctrl evt_irq_chk #(.NUM_EVT(NUM_EVT), .IW(IW)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .evt_raise_i (evt_raise_i),
  .ack_wr_i    (ack_wr_i),
  .fiq_o       (fiq_o),
  .cur_evt_o   (cur_evt_o),
  .pend_q      (pend_q),
  .retire_w    (retire_w)
);

// File: tb/sim_audio_evt_ctrl.sv
module sim_audio_evt_ctrl;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] evt_raise_i = '0;
  logic       ack_wr_i = 1'b0;
  logic       fiq_o;
  logic [2:0] cur_evt_o;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  // Reference state, built from the requirements.
  logic [7:0] m_pend;
  int         m_evt;
  int         m_cnt;

  audio_evt_ctrl u0 (
    .clk         (clk),
    .rst_n       (rst_n),
    .evt_raise_i (evt_raise_i),
    .ack_wr_i    (ack_wr_i),
    .fiq_o       (fiq_o),
    .cur_evt_o   (cur_evt_o)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic compare(input string tag);
    checks++;
    if (int'(cur_evt_o) != m_evt) begin
      failures++;
      $display("FAIL %s cur_evt actual=%0d expected=%0d", tag, cur_evt_o, m_evt);
    end
    checks++;
    if (fiq_o != (m_pend != 0)) begin
      failures++;
      $display("FAIL %s fiq actual=%0b expected=%0b", tag, fiq_o, (m_pend != 0));
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    evt_raise_i = '0;
    ack_wr_i = 1'b0;
    m_pend = 8'h04;
    m_evt = 2;
    m_cnt = 0;
    @(negedge clk);
    compare("R1 in reset");
    rst_n = 1'b1;
    #(CLK_PERIOD/4);
    compare("R1 after release");
  endtask

  task automatic step(input logic [7:0] r, input logic c, input string tag);
    bit ret;
    int lo;
    @(negedge clk);
    evt_raise_i = r;
    ack_wr_i = c;
    ret = c && (m_cnt == 3);
    if (c) m_cnt = ret ? 0 : m_cnt + 1;
    if (ret) begin
      lo = 8;
      for (int i = 7; i >= 0; i--) if (m_pend[i]) lo = i;
      if (lo < 8) begin
        m_pend[lo] = 1'b0;
        for (int j = 7; j >= lo; j--) if (m_pend[j]) m_evt = j;
      end
    end
    for (int i = 0; i < 8; i++) begin
      if (r[i]) begin
        m_pend[i] = 1'b1;
        if (m_evt == 0 || i < m_evt) m_evt = i;
      end
    end
    @(posedge clk);
    #(CLK_PERIOD/4);
    evt_raise_i = '0;
    ack_wr_i = 1'b0;
    compare(tag);
  endtask

  initial begin
    logic [15:0] lfsr;
    do_reset();
    // Sweep every raise pattern on top of the reset state, then drain the
    // set past empty so that the clear count wraps.
    for (int p = 0; p < 256; p++) begin
      do_reset();
      step(8'(p), 1'b0, "R3 R8 sweep raise");
      for (int k = 0; k < 10; k++) begin
        step('0, 1'b1, "R4 clear 1");
        step('0, 1'b1, "R4 clear 2");
        step('0, 1'b1, "R4 clear 3");
        step('0, 1'b1, "R5 R6 fourth clear");
      end
    end
    // Retire plus raise in one cycle, where the retire empties the set.
    do_reset();
    step('0, 1'b1, "R4 pre");
    step('0, 1'b1, "R4 pre");
    step('0, 1'b1, "R4 pre");
    step(8'h20, 1'b1, "R7 retire then raise");
    // Event 0 pending alongside others: retire 0 while raising 6.
    do_reset();
    step(8'h09, 1'b0, "R3 raise 0 and 3");
    step('0, 1'b1, "R4 pre");
    step('0, 1'b1, "R4 pre");
    step('0, 1'b1, "R4 pre");
    step(8'h40, 1'b1, "R7 retire 0 with raise");
    step(8'h04, 1'b0, "R8 raise pending event");
    // Long pseudo-random mix.
    do_reset();
    lfsr = 16'hACE1;
    for (int n = 0; n < 4000; n++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      step((lfsr[3:0] == 4'h0) ? (8'(1) << lfsr[6:4]) : 8'h00, lfsr[8] | lfsr[9],
           "R2 R7 random mix");
    end
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 190000);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule